// File: doc/BRIEF.md
# Hardware Cursor Overlay Pixel Mixer

This block is a streaming pixel stage. It sits between the scanout of an indexed frame store and the video output. For every pixel it receives the raster position and an 8-bit colour index. It decides whether the pixel lies inside a 64×64 hardware cursor window. It then emits either the colour-palette RGB value for the index or one of three cursor colours. The cursor shape is stored as 2 bits per pixel, packed into 16-bit words with eight words per cursor line.

The pattern memory and the colour palette are external synchronous-read memories. The block drives their addresses in the same cycle the pixel arrives and uses the data one cycle later. The three cursor colours arrive on a flat input. Three controls act on the output: a force-blank input blanks the picture, a cursor-disable input hides the cursor, and a depth selector marks the scanout format as supported or not.

Top module: `curs_overlay_mix`

## Requirements
- R1: Each pixel appears on the outputs exactly two clock edges after it is presented, with `outValid`, `outX` and `outY` carrying its valid flag and coordinates. A cycle with `inValid` low yields `outValid` low two edges later.
- R2: A pixel is inside the cursor when xc ≤ x < xc+64 and yc ≤ y < yc+64, compared without wrap-around even when the window reaches coordinate 4095.
- R3: The cursor origin is taken from `curPos`, with the X origin in bits 23:12 and the Y origin in bits 11:0.
- R4: For an inside pixel, with dx = x−xc and dy = y−yc, `patAddr` equals dy×8 + dx/8 combinationally in the cycle the pixel is presented. The pattern word is read one cycle later on `patData`.
- R5: The 2-bit cursor code of a pixel is bits [(dx mod 8)×2 +: 2] of its pattern word.
- R6: Code 0, and every pixel outside the window, shows the palette entry for `inIndex`. `palAddr` carries `inIndex` in the presentation cycle, and `palData` returns the entry one cycle later.
- R7: Codes 1, 2 and 3 show cursor colours 0, 1 and 2, where colour k occupies `curPal[24k +: 24]`.
- R8: While `cursorOff` is high, no pixel is treated as inside the cursor.
- R9: While `forceBlank` is high, the output RGB is zero whatever the index or the cursor content.
- R10: Only `depthSel` = 3 (8 bits per pixel) is supported. For any other value the output RGB is zero and `outDepthErr` is high for that pixel.
- R11: During reset, `outValid`, `outRgb` and `outDepthErr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming pixel is valid |
| inX | input | 12 | Pixel column |
| inY | input | 12 | Pixel row |
| inIndex | input | 8 | Colour index from the frame store |
| curPos | input | 24 | Cursor origin, X in 23:12, Y in 11:0 |
| forceBlank | input | 1 | Blank the whole picture |
| cursorOff | input | 1 | Hide the cursor |
| depthSel | input | 3 | Pixel depth code, 3 means 8 bits |
| patAddr | output | 9 | Cursor pattern word address |
| patData | input | 16 | Pattern word, one cycle after the address |
| palAddr | output | 8 | Colour palette address |
| palData | input | 24 | Palette RGB, one cycle after the address |
| curPal | input | 72 | Three 24-bit cursor colours |
| outValid | output | 1 | Output pixel valid |
| outX | output | 12 | Output pixel column |
| outY | output | 12 | Output pixel row |
| outRgb | output | 24 | Output colour, red in 23:16 |
| outDepthErr | output | 1 | Pixel was mixed at an unsupported depth |

## Verification
A cursor hit, force blank and an unsupported depth can all hold for the same pixel. The bench presents pixels where a non-transparent cursor code coincides with blanking, and others where it coincides with an unsupported depth. Black must win in both cases, and the depth flag must still be raised in the second. Back-to-back pixels, mixing cursor hits with palette lookups, check that each result lines up with its own coordinates across the two-stage pipeline.

// File: rtl/curs_overlay_pkg.sv
package curs_overlay_pkg;
  localparam int PAT_W = 16;
  localparam int SUB_W = $clog2(PAT_W / 2);

  typedef struct packed {
    logic             vld;
    logic             hit;
    logic             black;
    logic             badDepth;
    logic [SUB_W-1:0] sub;
  } mix_strobe_t;
endpackage

// File: rtl/curs_overlay_ctrl.sv
module curs_overlay_ctrl
  import curs_overlay_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int CUR_SIZE = 64,
  parameter int DEPTH_W  = 3,
  parameter int DEPTH8   = 3,
  localparam int CUR_LOG = $clog2(CUR_SIZE),
  localparam int PAT_AW  = 2 * CUR_LOG - SUB_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [COORD_W-1:0]   inX,
  input  logic [COORD_W-1:0]   inY,
  input  logic [2*COORD_W-1:0] curPos,
  input  logic                 forceBlank,
  input  logic                 cursorOff,
  input  logic [DEPTH_W-1:0]   depthSel,
  output logic [PAT_AW-1:0]    patAddr,
  output mix_strobe_t          stb,
  output logic [COORD_W-1:0]   stgX,
  output logic [COORD_W-1:0]   stgY
);
  logic [COORD_W-1:0] xCur, yCur;
  logic [COORD_W:0]   diffX, diffY;
  logic               inWinX, inWinY, hitNow, badNow;

  always_comb begin
    xCur   = curPos[2*COORD_W-1:COORD_W];
    yCur   = curPos[COORD_W-1:0];
    diffX  = {1'b0, inX} - {1'b0, xCur};
    diffY  = {1'b0, inY} - {1'b0, yCur};
    inWinX = !diffX[COORD_W] && (diffX[COORD_W-1:0] < COORD_W'(CUR_SIZE));
    inWinY = !diffY[COORD_W] && (diffY[COORD_W-1:0] < COORD_W'(CUR_SIZE));
    hitNow = inWinX && inWinY && !cursorOff;
    badNow = depthSel != DEPTH_W'(DEPTH8);
    patAddr = {diffY[CUR_LOG-1:0], diffX[CUR_LOG-1:SUB_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stb  <= '0;
      stgX <= '0;
      stgY <= '0;
    end else begin
      stb.vld      <= inValid;
      stb.hit      <= hitNow;
      stb.black    <= forceBlank || badNow;
      stb.badDepth <= badNow;
      stb.sub      <= diffX[SUB_W-1:0];
      stgX         <= inX;
      stgY         <= inY;
    end
  end

  // R8: a disabled cursor never produces a hit
  a_r8_off_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cursorOff |=> !stb.hit);

  // R2: a pixel left of the origin is never inside
  a_r2_left_miss: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inX < curPos[2*COORD_W-1:COORD_W]) |=> !stb.hit);
endmodule

// File: rtl/curs_overlay_dp.sv
module curs_overlay_dp
  import curs_overlay_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int COLOR_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mix_strobe_t          stb,
  input  logic [COORD_W-1:0]   stgX,
  input  logic [COORD_W-1:0]   stgY,
  input  logic [PAT_W-1:0]     patData,
  input  logic [COLOR_W-1:0]   palData,
  input  logic [3*COLOR_W-1:0] curPal,
  output logic                 outValid,
  output logic [COORD_W-1:0]   outX,
  output logic [COORD_W-1:0]   outY,
  output logic [COLOR_W-1:0]   outRgb,
  output logic                 outDepthErr
);
  logic [1:0]         code;
  logic [COLOR_W-1:0] mixRgb;

  always_comb begin
    code = patData[{stb.sub, 1'b0} +: 2];
    if (stb.black) begin
      mixRgb = '0;
    end else if (stb.hit) begin
      case (code)
        2'd1:    mixRgb = curPal[0*COLOR_W +: COLOR_W];
        2'd2:    mixRgb = curPal[1*COLOR_W +: COLOR_W];
        2'd3:    mixRgb = curPal[2*COLOR_W +: COLOR_W];
        default: mixRgb = palData;
      endcase
    end else begin
      mixRgb = palData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outX        <= '0;
      outY        <= '0;
      outRgb      <= '0;
      outDepthErr <= 1'b0;
    end else begin
      outValid    <= stb.vld;
      outX        <= stgX;
      outY        <= stgY;
      outRgb      <= mixRgb;
      outDepthErr <= stb.badDepth;
    end
  end

  // R9: blanked pixels leave black
  a_r9_blank_black: assert property (@(posedge clk) disable iff (!rstN)
    stb.vld && stb.black |=> outRgb == '0);

  // R10: unsupported depth raises the flag
  a_r10_depth_flag: assert property (@(posedge clk) disable iff (!rstN)
    stb.vld && stb.badDepth |=> outDepthErr && outRgb == '0);

  // R6: a miss passes the palette colour through
  a_r6_miss_palette: assert property (@(posedge clk) disable iff (!rstN)
    stb.vld && !stb.black && !stb.hit |=> outRgb == $past(palData));
endmodule

// File: rtl/curs_overlay_mix.sv
module curs_overlay_mix
  import curs_overlay_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int IDX_W    = 8,
  parameter int COLOR_W  = 24,
  parameter int CUR_SIZE = 64,
  parameter int DEPTH_W  = 3,
  parameter int DEPTH8   = 3,
  localparam int CUR_LOG = $clog2(CUR_SIZE),
  localparam int PAT_AW  = 2 * CUR_LOG - SUB_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [COORD_W-1:0]   inX,
  input  logic [COORD_W-1:0]   inY,
  input  logic [IDX_W-1:0]     inIndex,
  input  logic [2*COORD_W-1:0] curPos,
  input  logic                 forceBlank,
  input  logic                 cursorOff,
  input  logic [DEPTH_W-1:0]   depthSel,
  output logic [PAT_AW-1:0]    patAddr,
  input  logic [PAT_W-1:0]     patData,
  output logic [IDX_W-1:0]     palAddr,
  input  logic [COLOR_W-1:0]   palData,
  input  logic [3*COLOR_W-1:0] curPal,
  output logic                 outValid,
  output logic [COORD_W-1:0]   outX,
  output logic [COORD_W-1:0]   outY,
  output logic [COLOR_W-1:0]   outRgb,
  output logic                 outDepthErr
);
  mix_strobe_t        stb;
  logic [COORD_W-1:0] stgX, stgY;

  assign palAddr = inIndex;

  curs_overlay_ctrl #(
    .COORD_W(COORD_W), .CUR_SIZE(CUR_SIZE), .DEPTH_W(DEPTH_W), .DEPTH8(DEPTH8)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX), .inY(inY),
    .curPos(curPos), .forceBlank(forceBlank), .cursorOff(cursorOff),
    .depthSel(depthSel), .patAddr(patAddr), .stb(stb), .stgX(stgX), .stgY(stgY)
  );

  curs_overlay_dp #(.COORD_W(COORD_W), .COLOR_W(COLOR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stgX(stgX), .stgY(stgY),
    .patData(patData), .palData(palData), .curPal(curPal),
    .outValid(outValid), .outX(outX), .outY(outY), .outRgb(outRgb),
    .outDepthErr(outDepthErr)
  );

  // R1: valid pixels leave two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);

  // R1: idle cycles stay idle
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);
endmodule

// File: tb/curs_overlay_mix_tb.sv
module curs_overlay_mix_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] inX = '0, inY = '0;
  logic [7:0]  inIndex = '0;
  logic [23:0] curPos = '0;
  logic        forceBlank = 1'b0, cursorOff = 1'b0;
  logic [2:0]  depthSel = 3'd3;
  logic [8:0]  patAddr;
  logic [15:0] patData;
  logic [7:0]  palAddr;
  logic [23:0] palData;
  logic [71:0] curPal = {24'h778899, 24'h445566, 24'h112233};
  logic        outValid, outDepthErr;
  logic [11:0] outX, outY;
  logic [23:0] outRgb;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  curs_overlay_mix u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inX(inX), .inY(inY),
    .inIndex(inIndex), .curPos(curPos), .forceBlank(forceBlank),
    .cursorOff(cursorOff), .depthSel(depthSel), .patAddr(patAddr),
    .patData(patData), .palAddr(palAddr), .palData(palData), .curPal(curPal),
    .outValid(outValid), .outX(outX), .outY(outY), .outRgb(outRgb),
    .outDepthErr(outDepthErr)
  );

  function automatic logic [23:0] palOf(input logic [7:0] i);
    return {i, i ^ 8'hFF, i ^ 8'h5A};
  endfunction

  // word parity picks one of two code orders
  always @(posedge clk) begin
    patData <= patAddr[0] ? 16'h1B1B : 16'hE4E4;
    palData <= palOf(palAddr);
  end

  function automatic logic [23:0] expRgb(input logic [2:0] kind, input logic [7:0] i);
    case (kind)
      3'd0: return palOf(i);
      3'd1: return 24'h112233;
      3'd2: return 24'h445566;
      3'd3: return 24'h778899;
      default: return 24'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [23:0] pos;
    logic [11:0] x;
    logic [11:0] y;
    logic [7:0]  idx;
    logic        blank;
    logic        off;
    logic [2:0]  depth;
    logic [2:0]  kind;
    logic        err;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{24'h064032, 12'd10,   12'd10,  8'h07, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd100,  12'd50,  8'h20, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd101,  12'd50,  8'h21, 1'b0, 1'b0, 3'd3, 3'd1, 1'b0},
    '{24'h064032, 12'd102,  12'd51,  8'h22, 1'b0, 1'b0, 3'd3, 3'd2, 1'b0},
    '{24'h064032, 12'd103,  12'd60,  8'h23, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0},
    '{24'h064032, 12'd108,  12'd50,  8'h24, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0},
    '{24'h064032, 12'd109,  12'd113, 8'h25, 1'b0, 1'b0, 3'd3, 3'd2, 1'b0},
    '{24'h064032, 12'd163,  12'd50,  8'h44, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd164,  12'd50,  8'h45, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd99,   12'd50,  8'h46, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd100,  12'd114, 8'h47, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd100,  12'd49,  8'h48, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd101,  12'd50,  8'h49, 1'b0, 1'b1, 3'd3, 3'd0, 1'b0},
    '{24'h064032, 12'd101,  12'd50,  8'h4A, 1'b1, 1'b0, 3'd3, 3'd4, 1'b0},
    '{24'h064032, 12'd10,   12'd10,  8'h4B, 1'b1, 1'b0, 3'd3, 3'd4, 1'b0},
    '{24'h064032, 12'd101,  12'd50,  8'h4C, 1'b0, 1'b0, 3'd2, 3'd4, 1'b1},
    '{24'h064032, 12'd10,   12'd10,  8'h4D, 1'b0, 1'b0, 3'd7, 3'd4, 1'b1},
    '{24'h064032, 12'd102,  12'd50,  8'h4E, 1'b0, 1'b0, 3'd3, 3'd2, 1'b0},
    '{24'h005007, 12'd6,    12'd7,   8'h98, 1'b0, 1'b0, 3'd3, 3'd1, 1'b0},
    '{24'h005007, 12'd7,    12'd5,   8'h99, 1'b0, 1'b0, 3'd3, 3'd0, 1'b0},
    '{24'hFDC000, 12'd4095, 12'd0,   8'h9A, 1'b0, 1'b0, 3'd3, 3'd3, 1'b0}
  };

  task automatic drive(input logic [23:0] p, input logic [11:0] x, input logic [11:0] y,
                       input logic [7:0] i);
    curPos = p; inX = x; inY = y; inIndex = i; inValid = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R11: reset holds outputs low even with a valid pixel offered
    drive(24'h064032, 12'd101, 12'd50, 8'h11);
    repeat (3) @(negedge clk);
    chk("R11 valid", 32'(outValid), 32'd0);
    chk("R11 rgb", 32'(outRgb), 32'd0);
    chk("R11 flag", 32'(outDepthErr), 32'd0);
    inValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].pos, VECS[k].x, VECS[k].y, VECS[k].idx);
      forceBlank = VECS[k].blank;
      cursorOff  = VECS[k].off;
      depthSel   = VECS[k].depth;
      @(negedge clk);
      inValid = 1'b0;
      @(negedge clk);
      chk($sformatf("R1 valid v%0d", k), 32'(outValid), 32'd1);
      chk($sformatf("R1 xy v%0d", k), {8'h0, outX, outY}, {8'h0, VECS[k].x, VECS[k].y});
      chk($sformatf("R2/R5/R7/R9/R10 rgb v%0d", k), 32'(outRgb),
          32'(expRgb(VECS[k].kind, VECS[k].idx)));
      chk($sformatf("R10 flag v%0d", k), 32'(outDepthErr), 32'(VECS[k].err));
    end
    forceBlank = 1'b0; cursorOff = 1'b0; depthSel = 3'd3;

    // R4 and R6: read addresses in the presentation cycle
    drive(24'h064032, 12'd109, 12'd113, 8'hC3);
    #1;
    chk("R4 patAddr", 32'(patAddr), 32'd505);
    chk("R6 palAddr", 32'(palAddr), 32'hC3);
    drive(24'h064032, 12'd122, 12'd55, 8'hC4);
    #1;
    chk("R4 patAddr", 32'(patAddr), 32'd42);
    inValid = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);

    // R1: back-to-back stream
    drive(24'h064032, 12'd101, 12'd50, 8'h01);
    @(negedge clk);
    drive(24'h064032, 12'd102, 12'd50, 8'h02);
    @(negedge clk);
    chk("R1 stream a", {outValid, 7'h0, outRgb}, {1'b1, 7'h0, 24'h112233});
    drive(24'h064032, 12'd10, 12'd10, 8'h33);
    @(negedge clk);
    chk("R1 stream b", {outValid, 7'h0, outRgb}, {1'b1, 7'h0, 24'h445566});
    chk("R1 stream b x", 32'(outX), 32'd102);
    inValid = 1'b0;
    @(negedge clk);
    chk("R1 stream c", {outValid, 7'h0, outRgb}, {1'b1, 7'h0, palOf(8'h33)});
    @(negedge clk);
    chk("R1 idle", 32'(outValid), 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule